// File: doc/BRIEF.md
# ADC Capture Control Registers

This block is the software-facing register file for a capture front end that takes serial data from several ADC chips, each with eight serial lanes. A host writes 32-bit words at four addresses: a word bound for the three-wire configuration engine, a control word, and two lane-delay select words. The block turns these writes into one-cycle command pulses: front-end reset, snapshot request, demux-mode update and per-lane bitslip. It also produces per-lane delay-load strobes that travel with a 5-bit tap value.

Software leaves command bits set until it writes zero over them. The usual pattern is to write zero, then the command, then zero again. For that reason every action fires on the 0-to-1 transition of its bit and not on the write itself. Delay targets are split by lane parity. Even lanes are selected through the low select word and odd lanes through the high one. In both words the select bit for chip c, lane l sits at index c*4 + l/2. A read at address 0 returns a packed status word built from the status inputs.

All pins are plain control and status. There is no data stream and no back-pressure. A write is taken on any clock edge where `wr_en` is high. A read request is answered on `rdata` one cycle later.

Top module: `adc_capture_ctrl_regs`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every pulse and strobe output is low, `rdata` and `cfg_word` are zero, and all stored words are cleared. A command bit written after reset therefore fires again, even if it was set before reset.
- R2: When bit 20 of a write to address 1 goes from 0 to 1, `rst_pulse` is high for exactly the one cycle after that write's clock edge.
- R3: When bit 16 of a write to address 1 goes from 0 to 1, `snap_pulse` is high for exactly the one cycle after that write's clock edge.
- R4: When bit 26 of a write to address 1 goes from 0 to 1, `demux_pulse` is high for one cycle. `demux_mode` always shows bits 25:24 of the stored control word.
- R5: A 0-to-1 transition of chip-select bit 8+c (for c below the number of chips) raises `slip_pulse[c*8 + idx]` for one cycle. Here idx is control bits 7:5. At most one lane per chip pulses.
- R6: A 0-to-1 transition of bit c*4 + l/2 in the word at address 2 raises `dly_load[c*8 + l]` for one cycle, for even lane l. `dly_tap` always shows control bits 4:0.
- R7: A 0-to-1 transition of bit c*4 + (l-1)/2 in the word at address 3 raises `dly_load[c*8 + l]` for one cycle, for odd lane l.
- R8: Writing a word whose command or select bits are already set produces no pulse and no strobe, and a cleared bit produces nothing.
- R9: A read of address 0 returns, on the next cycle, board revision at bits 29:28, lock flags at 25:24, unit count at 23:20, controller revision at 19:18, auxiliary revision at 17:16 and serial readback at 15:0. All other bits are zero.
- R10: A read of address 1, 2 or 3 returns zero, and `rdata` is zero in any cycle that does not follow a read.
- R11: A write to address 0 stores the word on `cfg_word` and raises `cfg_wr` for the one following cycle.
- R12: Chip-select bits for chips that do not exist, and delay-select bits at or above NUM_CHIPS*4, cause no pulse or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, taken at the clock edge |
| rd_en | input | 1 | Read request |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| st_board_rev | input | 2 | Board revision status |
| st_lock | input | 2 | Clock lock flags |
| st_units | input | 4 | Number of capture units |
| st_ctrl_rev | input | 2 | Controller revision |
| st_aux_rev | input | 2 | Auxiliary revision |
| st_serial_rd | input | 16 | Three-wire engine readback |
| cfg_word | output | 32 | Stored three-wire configuration word |
| cfg_wr | output | 1 | One-cycle pulse after a configuration write |
| rst_pulse | output | 1 | Front-end reset command |
| snap_pulse | output | 1 | Snapshot request command |
| demux_pulse | output | 1 | Demux mode update command |
| demux_mode | output | 2 | Demux mode field |
| slip_pulse | output | NUM_CHIPS*8 | Per-lane bitslip pulses, lane c*8+l |
| dly_load | output | NUM_CHIPS*8 | Per-lane delay-load strobes, lane c*8+l |
| dly_tap | output | 5 | Delay tap that goes with `dly_load` |

## Verification
Each pulse, strobe and `cfg_wr` is due in the cycle right after the clock edge that takes the write. The edge-detect history register updates at that same edge, so the pulse drops one cycle later. `rdata` is due one cycle after the edge that samples `rd_en`. The bench changes inputs on the falling edge and samples at the falling edge after the capturing rising edge. It then samples once more a cycle later to confirm that every pulse has cleared. The stimulus table keeps the stored words in a known state, so a repeated or reserved write is checked for producing no output in that same sampling slot.

// File: rtl/acif_pkg.sv
package acif_pkg;

  typedef enum logic [1:0] {
    ADR_SERIAL_CFG = 2'd0,
    ADR_CONTROL    = 2'd1,
    ADR_DSEL_EVEN  = 2'd2,
    ADR_DSEL_ODD   = 2'd3
  } acif_addr_e;

  // Control word field positions (decoded by software; fixed)
  localparam int CB_DEMUX_WR  = 26;
  localparam int CB_MODE_LO   = 24;
  localparam int CB_RESET     = 20;
  localparam int CB_SNAP      = 16;
  localparam int CB_CHIP_LO   = 8;
  localparam int CB_LANE_LO   = 5;
  localparam int CB_TAP_LO    = 0;
  localparam int TAP_W        = 5;
  localparam int LANE_IDX_W   = 3;
  localparam int MODE_W       = 2;
  localparam int CHIP_FIELD_W = 8;

  typedef struct packed {
    logic                  demux_wr;
    logic [MODE_W-1:0]     demux_mode;
    logic                  reset_cmd;
    logic                  snap_cmd;
    logic [LANE_IDX_W-1:0] slip_lane;
    logic [TAP_W-1:0]      tap;
  } ctrl_fields_t;

  function automatic logic [31:0] pack_status(
    input logic [1:0]  board_rev,
    input logic [1:0]  lock,
    input logic [3:0]  units,
    input logic [1:0]  ctrl_rev,
    input logic [1:0]  aux_rev,
    input logic [15:0] serial_rd
  );
    pack_status = {2'b00, board_rev, 2'b00, lock, units, ctrl_rev, aux_rev, serial_rd};
  endfunction

endpackage

// File: rtl/acif_bus_decode.sv
module acif_bus_decode
  import acif_pkg::*;
#(
  parameter int NUM_CHIPS = 3,
  parameter int SEL_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [1:0]           addr,
  input  logic [31:0]          wdata,
  input  logic [31:0]          status_word,
  output logic [31:0]          cfg_q,
  output logic                 cfg_wr,
  output ctrl_fields_t         ctrl_q,
  output logic [NUM_CHIPS-1:0] chips_q,
  output logic [SEL_W-1:0]     sel_even_q,
  output logic [SEL_W-1:0]     sel_odd_q,
  output logic [31:0]          rdata
);

  acif_addr_e   wa;
  ctrl_fields_t ctrl_d;

  assign wa = acif_addr_e'(addr);

  always_comb begin
    ctrl_d.demux_wr   = wdata[CB_DEMUX_WR];
    ctrl_d.demux_mode = wdata[CB_MODE_LO +: MODE_W];
    ctrl_d.reset_cmd  = wdata[CB_RESET];
    ctrl_d.snap_cmd   = wdata[CB_SNAP];
    ctrl_d.slip_lane  = wdata[CB_LANE_LO +: LANE_IDX_W];
    ctrl_d.tap        = wdata[CB_TAP_LO +: TAP_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      cfg_wr     <= 1'b0;
      ctrl_q     <= '0;
      chips_q    <= '0;
      sel_even_q <= '0;
      sel_odd_q  <= '0;
      rdata      <= '0;
    end else begin
      cfg_wr <= wr_en && (wa == ADR_SERIAL_CFG);
      if (wr_en) begin
        unique case (wa)
          ADR_SERIAL_CFG: cfg_q <= wdata;
          ADR_CONTROL: begin
            ctrl_q  <= ctrl_d;
            chips_q <= wdata[CB_CHIP_LO +: NUM_CHIPS];
          end
          ADR_DSEL_EVEN: sel_even_q <= wdata[SEL_W-1:0];
          ADR_DSEL_ODD:  sel_odd_q  <= wdata[SEL_W-1:0];
        endcase
      end
      rdata <= (rd_en && (wa == ADR_SERIAL_CFG)) ? status_word : '0;
    end
  end

endmodule

// File: rtl/acif_rise_det.sv
module acif_rise_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

endmodule

// File: rtl/acif_lane_map.sv
module acif_lane_map
  import acif_pkg::*;
#(
  parameter int NUM_CHIPS = 3,
  parameter int LANES     = 8
) (
  input  logic [NUM_CHIPS-1:0]           chip_rise,
  input  logic [LANE_IDX_W-1:0]          lane_idx,
  input  logic [NUM_CHIPS*(LANES/2)-1:0] even_rise,
  input  logic [NUM_CHIPS*(LANES/2)-1:0] odd_rise,
  output logic [NUM_CHIPS*LANES-1:0]     slip,
  output logic [NUM_CHIPS*LANES-1:0]     dload
);

  localparam int HALF = LANES / 2;

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int K = c * HALF + l / 2;
      assign slip[c*LANES + l] = chip_rise[c] && (lane_idx == LANE_IDX_W'(l));
      if (l % 2 == 0) begin : g_even
        assign dload[c*LANES + l] = even_rise[K];
      end else begin : g_odd
        assign dload[c*LANES + l] = odd_rise[K];
      end
    end
  end

endmodule

// File: rtl/adc_capture_ctrl_regs.sv
module adc_capture_ctrl_regs
  import acif_pkg::*;
#(
  parameter int NUM_CHIPS = 3,
  parameter int LANES     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [1:0]                   addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata,
  input  logic [1:0]                   st_board_rev,
  input  logic [1:0]                   st_lock,
  input  logic [3:0]                   st_units,
  input  logic [1:0]                   st_ctrl_rev,
  input  logic [1:0]                   st_aux_rev,
  input  logic [15:0]                  st_serial_rd,
  output logic [31:0]                  cfg_word,
  output logic                         cfg_wr,
  output logic                         rst_pulse,
  output logic                         snap_pulse,
  output logic                         demux_pulse,
  output logic [1:0]                   demux_mode,
  output logic [NUM_CHIPS*LANES-1:0]   slip_pulse,
  output logic [NUM_CHIPS*LANES-1:0]   dly_load,
  output logic [4:0]                   dly_tap
);

  localparam int SEL_W = NUM_CHIPS * (LANES / 2);
  localparam int CMD_W = 3 + NUM_CHIPS;

  logic [31:0]          status_word;
  ctrl_fields_t         ctrl_q;
  logic [NUM_CHIPS-1:0] chips_q;
  logic [SEL_W-1:0]     sel_even_q, sel_odd_q;
  logic [SEL_W-1:0]     even_rise, odd_rise;
  logic [CMD_W-1:0]     cmd_lvl, cmd_rise;

  assign status_word = pack_status(st_board_rev, st_lock, st_units,
                                   st_ctrl_rev, st_aux_rev, st_serial_rd);

  acif_bus_decode #(.NUM_CHIPS(NUM_CHIPS), .SEL_W(SEL_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .status_word(status_word),
    .cfg_q      (cfg_word),
    .cfg_wr     (cfg_wr),
    .ctrl_q     (ctrl_q),
    .chips_q    (chips_q),
    .sel_even_q (sel_even_q),
    .sel_odd_q  (sel_odd_q),
    .rdata      (rdata)
  );

  assign cmd_lvl = {ctrl_q.demux_wr, ctrl_q.reset_cmd, ctrl_q.snap_cmd, chips_q};

  acif_rise_det #(.W(CMD_W)) u_cmd_edge (
    .clk (clk), .rst (rst), .lvl (cmd_lvl), .rise(cmd_rise)
  );

  acif_rise_det #(.W(SEL_W)) u_even_edge (
    .clk (clk), .rst (rst), .lvl (sel_even_q), .rise(even_rise)
  );

  acif_rise_det #(.W(SEL_W)) u_odd_edge (
    .clk (clk), .rst (rst), .lvl (sel_odd_q), .rise(odd_rise)
  );

  assign demux_pulse = cmd_rise[CMD_W-1];
  assign rst_pulse   = cmd_rise[CMD_W-2];
  assign snap_pulse  = cmd_rise[CMD_W-3];
  assign demux_mode  = ctrl_q.demux_mode;
  assign dly_tap     = ctrl_q.tap;

  acif_lane_map #(.NUM_CHIPS(NUM_CHIPS), .LANES(LANES)) u_map (
    .chip_rise(cmd_rise[NUM_CHIPS-1:0]),
    .lane_idx (ctrl_q.slip_lane),
    .even_rise(even_rise),
    .odd_rise (odd_rise),
    .slip     (slip_pulse),
    .dload    (dly_load)
  );

endmodule

// File: rtl/adc_capture_ctrl_regs_chk.sv
module adc_capture_ctrl_regs_chk #(
  parameter int NUM_CHIPS = 3,
  parameter int LANES     = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic                       rd_en,
  input logic [1:0]                 addr,
  input logic [31:0]                wdata,
  input logic [31:0]                rdata,
  input logic                       cfg_wr,
  input logic                       rst_pulse,
  input logic                       snap_pulse,
  input logic                       demux_pulse,
  input logic [NUM_CHIPS*LANES-1:0] slip_pulse,
  input logic [NUM_CHIPS*LANES-1:0] dly_load
);

  // R2
  rst_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |-> $past(wr_en && addr == 2'd1 && wdata[20]));

  // R2
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    rst_pulse |=> !rst_pulse);

  // R3
  snap_single_chk: assert property (@(posedge clk) disable iff (rst)
    snap_pulse |=> !snap_pulse);

  // R3
  snap_cause_chk: assert property (@(posedge clk) disable iff (rst)
    snap_pulse |-> $past(wr_en && addr == 2'd1 && wdata[16]));

  // R4
  demux_single_chk: assert property (@(posedge clk) disable iff (rst)
    demux_pulse |=> !demux_pulse);

  // R5
  slip_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|slip_pulse) |-> $past(wr_en && addr == 2'd1));

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    // R5
    slip_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(slip_pulse[c*LANES +: LANES]));
  end

  // R6
  dly_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|dly_load) |-> $past(wr_en && addr[1]));

  // R9
  rdata_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (rdata != 32'd0) |-> $past(rd_en && addr == 2'd0));

  // R11
  cfg_cause_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |-> $past(wr_en && addr == 2'd0));

endmodule

bind adc_capture_ctrl_regs adc_capture_ctrl_regs_chk #(
  .NUM_CHIPS(NUM_CHIPS), .LANES(LANES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .cfg_wr     (cfg_wr),
  .rst_pulse  (rst_pulse),
  .snap_pulse (snap_pulse),
  .demux_pulse(demux_pulse),
  .slip_pulse (slip_pulse),
  .dly_load   (dly_load)
);

// File: tb/adc_capture_ctrl_regs_bench.sv
module adc_capture_ctrl_regs_bench;

  localparam int NL = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  st_board_rev = '0, st_lock = '0, st_ctrl_rev = '0, st_aux_rev = '0;
  logic [3:0]  st_units = '0;
  logic [15:0] st_serial_rd = '0;
  logic [31:0] cfg_word;
  logic        cfg_wr, rst_pulse, snap_pulse, demux_pulse;
  logic [1:0]  demux_mode;
  logic [NL-1:0] slip_pulse, dly_load;
  logic [4:0]  dly_tap;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  adc_capture_ctrl_regs u_adc_capture_ctrl_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .st_board_rev(st_board_rev), .st_lock(st_lock), .st_units(st_units),
    .st_ctrl_rev(st_ctrl_rev), .st_aux_rev(st_aux_rev), .st_serial_rd(st_serial_rd),
    .cfg_word(cfg_word), .cfg_wr(cfg_wr), .rst_pulse(rst_pulse),
    .snap_pulse(snap_pulse), .demux_pulse(demux_pulse), .demux_mode(demux_mode),
    .slip_pulse(slip_pulse), .dly_load(dly_load), .dly_tap(dly_tap)
  );

  typedef struct packed {
    logic [1:0]    a;
    logic [31:0]   d;
    logic          r;
    logic          s;
    logic          m;
    logic [1:0]    mode;
    logic [NL-1:0] slip;
    logic [NL-1:0] dly;
    logic [4:0]    tap;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 32'h0010_0000, 1'b1, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h00}, // R2
    '{2'd1, 32'h0010_0000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h00}, // R8 repeat
    '{2'd1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h00}, // R8 clear
    '{2'd1, 32'h0001_0000, 1'b0, 1'b1, 1'b0, 2'd0, 24'h0,      24'h0,      5'h00}, // R3
    '{2'd1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h00},
    '{2'd1, 32'h0600_0000, 1'b0, 1'b0, 1'b1, 2'd2, 24'h0,      24'h0,      5'h00}, // R4
    '{2'd1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h00},
    '{2'd1, 32'h0000_0260, 1'b0, 1'b0, 1'b0, 2'd0, 24'h000800, 24'h0,      5'h00}, // R5 chip1 lane3
    '{2'd1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h00},
    '{2'd1, 32'h0000_05E0, 1'b0, 1'b0, 1'b0, 2'd0, 24'h800080, 24'h0,      5'h00}, // R5 chips0,2 lane7
    '{2'd1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h00},
    '{2'd1, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h00}, // R12 chip5
    '{2'd1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h00},
    '{2'd1, 32'h0000_0015, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h15}, // R6 tap
    '{2'd2, 32'h0000_0040, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h001000, 5'h15}, // R6 chip1 lane4
    '{2'd2, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h15},
    '{2'd3, 32'h0000_0801, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h800002, 5'h15}, // R7 lanes 1,23
    '{2'd3, 32'h0000_0801, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h15}, // R8
    '{2'd3, 32'hFFFF_F801, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h15}, // R12 high bits
    '{2'd3, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 2'd0, 24'h0,      24'h0,      5'h15}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulses_idle(input string req);
    chk(req, {29'd0, rst_pulse, snap_pulse, demux_pulse}, 32'd0);
    chk(req, {8'd0, slip_pulse}, 32'd0);
    chk(req, {8'd0, dly_load}, 32'd0);
    chk(req, {31'd0, cfg_wr}, 32'd0);
  endtask

  // Write is taken at the next rising edge; returns at the falling edge after it.
  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_read(input logic [1:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] exp_status();
    return (32'(st_board_rev) << 28) | (32'(st_lock) << 24) | (32'(st_units) << 20) |
           (32'(st_ctrl_rev) << 18) | (32'(st_aux_rev) << 16) | 32'(st_serial_rd);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    pulses_idle("R1");
    chk("R1", rdata, 32'd0);
    chk("R1", cfg_word, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    pulses_idle("R1");
    chk("R1", {27'd0, dly_tap}, 32'd0);

    // Table walk: R2..R8, R12
    for (int i = 0; i < NV; i++) begin
      string dreq;
      dreq = (VECS[i].a == 2'd3) ? "R7" : "R6";
      do_write(VECS[i].a, VECS[i].d);
      chk("R2", {31'd0, rst_pulse},   {31'd0, VECS[i].r});
      chk("R3", {31'd0, snap_pulse},  {31'd0, VECS[i].s});
      chk("R4", {31'd0, demux_pulse}, {31'd0, VECS[i].m});
      chk("R4", {30'd0, demux_mode},  {30'd0, VECS[i].mode});
      chk("R5", {8'd0, slip_pulse},   {8'd0, VECS[i].slip});
      chk(dreq, {8'd0, dly_load},     {8'd0, VECS[i].dly});
      chk("R6", {27'd0, dly_tap},     {27'd0, VECS[i].tap});
      @(negedge clk);
      pulses_idle("R8");
    end

    // R11: configuration write
    do_write(2'd0, 32'hA5C3_0F96);
    chk("R11", {31'd0, cfg_wr}, 32'd1);
    chk("R11", cfg_word, 32'hA5C3_0F96);
    chk("R11", {29'd0, rst_pulse, snap_pulse, demux_pulse}, 32'd0);
    @(negedge clk);
    chk("R11", {31'd0, cfg_wr}, 32'd0);
    chk("R11", cfg_word, 32'hA5C3_0F96);

    // R9: status read
    st_board_rev = 2'd2; st_lock = 2'd3; st_units = 4'hA;
    st_ctrl_rev = 2'd1; st_aux_rev = 2'd2; st_serial_rd = 16'hBEEF;
    do_read(2'd0);
    chk("R9", rdata, exp_status());
    chk("R9", rdata, 32'h23A6_BEEF);
    @(negedge clk);
    chk("R10", rdata, 32'd0);

    // R10: other addresses read zero while their words are non-zero
    do_write(2'd2, 32'h0000_0003);
    do_read(2'd1);
    chk("R10", rdata, 32'd0);
    do_read(2'd2);
    chk("R10", rdata, 32'd0);
    do_read(2'd3);
    chk("R10", rdata, 32'd0);

    // R2 R3 R4: several commands in one write
    do_write(2'd1, 32'h0411_0000);
    chk("R2", {31'd0, rst_pulse}, 32'd1);
    chk("R3", {31'd0, snap_pulse}, 32'd1);
    chk("R4", {31'd0, demux_pulse}, 32'd1);
    chk("R4", {30'd0, demux_mode}, 32'd0);

    // R1: reset clears stored words, so a held command fires again
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", cfg_word, 32'd0);
    pulses_idle("R1");
    rst = 1'b0;
    do_write(2'd1, 32'h0411_0000);
    chk("R1", {29'd0, rst_pulse, snap_pulse, demux_pulse}, 32'd7);
    do_write(2'd2, 32'h0000_0003);
    chk("R1", {8'd0, dly_load}, 32'h0000_0005);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule